// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit integer operand into a binary64 value. The integer may be signed or unsigned, and it may be 32 or 64 bits wide. The caller can instead ask for a binary32-precision result. In that case the value is rounded to 24 significant bits and then handed back widened into binary64 encoding, so the consumer always receives one 64-bit format.

Alongside the value, the block reports:
- whether rounding lost information,
- whether the significand was incremented,
- a small class code for the rounded result,
- a status-update enable, which tells the surrounding unit whether it may commit those flags.

A sticky summary bit remembers that some delivered result was inexact.

A 32-bit source converted to binary64 always fits. That case skips rounding, leaves every flag low and holds the status-update enable low. Operands enter with a valid strobe. Results leave with their own valid strobe exactly two clock cycles later, and a new operand may enter every cycle.

Top module: `itf_convert`

## Requirements
- R1: The 2-bit type code selects the source. Code 0 is signed 32-bit and code 1 is unsigned 32-bit; both read only operand bits 31:0. Code 2 is signed 64-bit and code 3 is unsigned 64-bit; both read the whole operand.
- R2: A negative signed source gives sign bit 63 = 1, with the magnitude taken from its two's complement. This includes the most negative values of both widths. A zero operand always gives +0 (all 64 result bits clear).
- R3: When the binary64 target is selected (single select = 0) with type code 0 or 1, the result is exact for every rounding mode. The inexact and rounded-up flags are 0 and the status-update enable is 0.
- R4: In every other case the status-update enable is 1 and the value is rounded according to the rounding mode. The encodings are 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R5: With single select = 1, the value is rounded to a 24-bit significand. It is delivered as the binary64 encoding of that same number, so result bits 28:0 are zero.
- R6: The inexact flag is 1 exactly when rounding discarded nonzero bits.
- R7: The rounded-up flag is 1 exactly when rounding incremented the significand. It is never set without the inexact flag.
- R8: The sticky summary output rises together with the first delivered result whose status-update enable and inexact flag are both 1. It stays high until reset.
- R9: The class code is 00100 for a positive nonzero result, 01000 for a negative nonzero result and 00010 for zero. No other code is ever produced.
- R10: A result appears with out_valid exactly two clock cycles after its operand was accepted with in_valid. Synchronous active-low reset clears out_valid and the sticky summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 64 | Integer operand |
| in_type | input | 2 | Source type code |
| in_rmode | input | 2 | Rounding mode |
| in_single | input | 1 | 1 = round at binary32 precision |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Result in binary64 encoding |
| out_inexact | output | 1 | Rounding discarded nonzero bits |
| out_rounded_up | output | 1 | Significand was incremented |
| out_class | output | 5 | Result class code |
| out_status_we | output | 1 | Flags may be committed |
| out_sticky | output | 1 | Sticky inexact summary |

## Verification
Directed operands cover the following, each of which separates a different fault:
- Exact 32-bit cases with arbitrary upper operand bits. These show whether the type code really ignores the high word, and whether rounding stays out of the exact path.
- 2^53+1, 2^53+3 and their negatives under all four modes. These distinguish ties-to-even from plain round-half-up, and show whether the directed modes look at the sign.
- All ones as an unsigned 64-bit value. This exercises the carry out of the significand into the exponent.
- Binary32-target operands near 2^24. These reveal a datapath that rounds at the wrong precision.

A long pseudo-random run then mixes all types, modes and targets. It uses operands of scattered magnitude and gaps in the valid strobe.

// File: rtl/itf_pkg.sv
// Package itf_pkg
// Shared widths, encodings and the inter-stage record of the converter.
// Assumes an IEEE binary64 output format and binary32 (24-bit) alternate precision.
package itf_pkg;

    localparam int OPW       = 64;
    localparam int HALFW     = OPW / 2;
    localparam int POSW      = $clog2(OPW);
    localparam int DBL_EXPW  = 11;
    localparam int DBL_FRACW = 52;
    localparam int DBL_PREC  = DBL_FRACW + 1;
    localparam int DBL_BIAS  = 1023;
    localparam int SGL_PREC  = 24;
    localparam int CLSW      = 5;

    typedef enum logic [1:0] {
        SRC_S32 = 2'd0,
        SRC_U32 = 2'd1,
        SRC_S64 = 2'd2,
        SRC_U64 = 2'd3
    } src_type_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rmode_e;

    localparam logic [CLSW-1:0] CLS_POS_NORM = 5'b00100;
    localparam logic [CLSW-1:0] CLS_NEG_NORM = 5'b01000;
    localparam logic [CLSW-1:0] CLS_POS_ZERO = 5'b00010;

    // Normalised operand handed from the first to the second stage
    typedef struct packed {
        logic            valid;
        logic            neg;
        logic [POSW-1:0] msb;
        logic [OPW-1:0]  norm;
        logic [1:0]      rmode;
        logic            single;
        logic            exact;
    } norm_t;

endpackage

// File: rtl/itf_magnitude.sv
// Module itf_magnitude
// Combinational: picks the source field named by the type code and returns
// its sign and unsigned magnitude. Assumes two's complement signed sources;
// the most negative value maps to a magnitude with only the top bit set.
module itf_magnitude
    import itf_pkg::*;
(
    input  logic [OPW-1:0] operand,
    input  logic [1:0]     src_type,
    output logic           neg,
    output logic [OPW-1:0] mag
);

    logic [OPW-1:0] ext;

    // Select and sign-extend the source, then negate when negative
    always_comb begin
        ext = '0;
        neg = 1'b0;
        case (src_type_e'(src_type))
            SRC_S32: begin
                neg = operand[HALFW-1];
                ext = {{HALFW{operand[HALFW-1]}}, operand[HALFW-1:0]};
            end
            SRC_U32: ext = {{HALFW{1'b0}}, operand[HALFW-1:0]};
            SRC_S64: begin
                neg = operand[OPW-1];
                ext = operand;
            end
            default: ext = operand;
        endcase
        mag = neg ? (~ext + 1'b1) : ext;
    end

endmodule

// File: rtl/itf_normalize.sv
// Module itf_normalize
// Combinational: finds the leading one of the magnitude and shifts it to the
// top bit. Assumes a zero magnitude yields norm = 0 (msb is then don't-care).
module itf_normalize
    import itf_pkg::*;
#(
    parameter int W  = OPW,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  mag,
    output logic [PW-1:0] msb,
    output logic [W-1:0]  norm
);

    logic [PW-1:0] lead;
    logic          found;

    // Priority search for the highest set bit
    always_comb begin
        lead  = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && mag[i]) begin
                lead  = PW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end

    assign norm = mag << lead;
    assign msb  = PW'(W - 1) - lead;

endmodule

// File: rtl/itf_round.sv
// Module itf_round
// Combinational: rounds the normalised significand at binary64 and binary32
// precision in parallel lanes, selects one lane and packs a binary64 word.
// Assumes the exponent never overflows (integer sources stay below 2^64).
module itf_round
    import itf_pkg::*;
(
    input  norm_t                st,
    output logic [OPW-1:0]       result,
    output logic                 inexact,
    output logic                 rounded_up,
    output logic [CLSW-1:0]      cls,
    output logic                 status_we
);

    logic [1:0]           lane_inexact;
    logic [1:0]           lane_inc;
    logic [1:0]           lane_carry;
    logic [1:0]           lane_hid;
    logic [DBL_FRACW-1:0] lane_frac [2];

    // Lane 0 rounds to binary64 precision, lane 1 to binary32 precision
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int P = (g == 0) ? DBL_PREC : SGL_PREC;
        logic [P-1:0] sig;
        logic         grd;
        logic         stk;
        logic         inc;
        logic [P:0]   sum;

        // Guard/sticky extraction and the rounding-mode increment decision
        always_comb begin
            sig = st.norm[OPW-1 -: P];
            grd = st.norm[OPW-1-P];
            stk = |st.norm[OPW-2-P:0];
            case (rmode_e'(st.rmode))
                RM_NEAREST: inc = grd & (stk | sig[0]);
                RM_ZERO:    inc = 1'b0;
                RM_UP:      inc = (grd | stk) & ~st.neg;
                default:    inc = (grd | stk) & st.neg;
            endcase
            sum = {1'b0, sig} + {{P{1'b0}}, inc};
        end

        assign lane_inexact[g] = grd | stk;
        assign lane_inc[g]     = inc;
        assign lane_carry[g]   = sum[P];
        assign lane_hid[g]     = sum[P-1];
        assign lane_frac[g]    = DBL_FRACW'(sum[P-2:0]) << (DBL_FRACW - P + 1);
    end

    logic                sel;
    logic                is_zero;
    logic [DBL_EXPW-1:0] exp_f;

    // Lane selection, packing, classification and flag gating
    always_comb begin
        sel     = st.single;
        is_zero = ~(lane_hid[sel] | lane_carry[sel]);
        exp_f   = DBL_EXPW'(DBL_BIAS) + DBL_EXPW'(st.msb) + DBL_EXPW'(lane_carry[sel]);
        if (is_zero) begin
            result = '0;
            cls    = CLS_POS_ZERO;
        end else begin
            result = {st.neg, exp_f, lane_frac[sel]};
            cls    = st.neg ? CLS_NEG_NORM : CLS_POS_NORM;
        end
        inexact    = lane_inexact[sel] & ~st.exact;
        rounded_up = lane_inc[sel] & ~st.exact;
        status_we  = ~st.exact;
    end

endmodule

// File: rtl/itf_convert.sv
// Module itf_convert
// Two-stage integer to binary64/binary32 converter. Stage A captures sign,
// leading-one position and normalised magnitude; stage B captures the rounded,
// packed result and flags. Assumes one operand per cycle at most, no stall.
module itf_convert
    import itf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [63:0]     in_operand,
    input  logic [1:0]      in_type,
    input  logic [1:0]      in_rmode,
    input  logic            in_single,
    output logic            out_valid,
    output logic [63:0]     out_result,
    output logic            out_inexact,
    output logic            out_rounded_up,
    output logic [4:0]      out_class,
    output logic            out_status_we,
    output logic            out_sticky
);

    logic           a_neg;
    logic [OPW-1:0] a_mag;
    logic [POSW-1:0] a_msb;
    logic [OPW-1:0] a_norm;
    norm_t          nxt_a;
    norm_t          st_a;

    logic [OPW-1:0]  r_result;
    logic            r_inexact;
    logic            r_up;
    logic [CLSW-1:0] r_cls;
    logic            r_we;

    itf_magnitude u_mag (
        .operand  (in_operand),
        .src_type (in_type),
        .neg      (a_neg),
        .mag      (a_mag)
    );

    itf_normalize #(.W(OPW)) u_norm (
        .mag  (a_mag),
        .msb  (a_msb),
        .norm (a_norm)
    );

    // Assemble the stage A record from the front-end results
    always_comb begin
        nxt_a.valid  = in_valid;
        nxt_a.neg    = a_neg;
        nxt_a.msb    = a_msb;
        nxt_a.norm   = a_norm;
        nxt_a.rmode  = in_rmode;
        nxt_a.single = in_single;
        nxt_a.exact  = ~in_single & ~in_type[1];
    end

    // Stage A register
    always_ff @(posedge clk) begin
        if (!rst_n) st_a <= '0;
        else        st_a <= nxt_a;
    end

    itf_round u_rnd (
        .st         (st_a),
        .result     (r_result),
        .inexact    (r_inexact),
        .rounded_up (r_up),
        .cls        (r_cls),
        .status_we  (r_we)
    );

    // Stage B register driving the result ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_result     <= '0;
            out_inexact    <= 1'b0;
            out_rounded_up <= 1'b0;
            out_class      <= '0;
            out_status_we  <= 1'b0;
        end else begin
            out_valid      <= st_a.valid;
            out_result     <= r_result;
            out_inexact    <= r_inexact;
            out_rounded_up <= r_up;
            out_class      <= r_cls;
            out_status_we  <= r_we;
        end
    end

    // Sticky inexact summary, set alongside the result that raises it
    always_ff @(posedge clk) begin
        if (!rst_n)                              out_sticky <= 1'b0;
        else if (st_a.valid & r_we & r_inexact)  out_sticky <= 1'b1;
    end

endmodule

// File: rtl/itf_convert_chk.sv
// Module itf_convert_chk
// Port-level protocol and flag-consistency properties of itf_convert.
// Assumes it is bound to every instance of the converter.
module itf_convert_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] in_type,
    input logic       in_single,
    input logic       out_valid,
    input logic [63:0] out_result,
    input logic       out_inexact,
    input logic       out_rounded_up,
    input logic [4:0] out_class,
    input logic       out_status_we,
    input logic       out_sticky
);

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    p_exact_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_status_we) |-> (!out_inexact && !out_rounded_up));

    p_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_status_we == ($past(in_single, 2) | $past(in_type[1], 2))));

    p_widened_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_single, 2)) |-> (out_result[28:0] == 29'd0));

    p_up_needs_inexact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rounded_up) |-> out_inexact);

    p_sticky_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_sticky |=> out_sticky);

    p_class_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_class) == 1 && !out_class[4] && !out_class[0]));

    p_class_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_result[63] == (out_class == 5'b01000)));

endmodule

bind itf_convert itf_convert_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_type        (in_type),
    .in_single      (in_single),
    .out_valid      (out_valid),
    .out_result     (out_result),
    .out_inexact    (out_inexact),
    .out_rounded_up (out_rounded_up),
    .out_class      (out_class),
    .out_status_we  (out_status_we),
    .out_sticky     (out_sticky)
);

// File: tb/itf_convert_tb.sv
module itf_convert_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_type = '0;
    logic [1:0]  in_rmode = '0;
    logic        in_single = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_inexact;
    logic        out_rounded_up;
    logic [4:0]  out_class;
    logic        out_status_we;
    logic        out_sticky;

    always #4 clk = ~clk;

    itf_convert u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_operand     (in_operand),
        .in_type        (in_type),
        .in_rmode       (in_rmode),
        .in_single      (in_single),
        .out_valid      (out_valid),
        .out_result     (out_result),
        .out_inexact    (out_inexact),
        .out_rounded_up (out_rounded_up),
        .out_class      (out_class),
        .out_status_we  (out_status_we),
        .out_sticky     (out_sticky)
    );

    typedef struct {
        bit        v;
        bit [63:0] res;
        bit        ix;
        bit        up;
        bit [4:0]  cls;
        bit        we;
        string     tag;
    } exp_t;

    exp_t        pipe[$];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          sticky_m = 1'b0;
    bit          done = 1'b0;
    bit [63:0]   lfsr = 64'h9E37_79B9_7F4A_7C15;

    // Reference: exact integer arithmetic on the magnitude
    function automatic exp_t model(bit [63:0] op, bit [1:0] ty, bit [1:0] rm, bit sg, string tag);
        exp_t e;
        bit neg;
        bit up;
        longint unsigned mag, q, r, half;
        int top, p, sh;
        e.v = 1'b1; e.tag = tag; e.ix = 1'b0; e.up = 1'b0;
        e.we = sg | ty[1];
        neg = 1'b0;
        case (ty)
            2'd0: begin
                neg = op[31];
                mag = neg ? (64'd0 - {32'hFFFF_FFFF, op[31:0]}) : {32'd0, op[31:0]};
            end
            2'd1: mag = {32'd0, op[31:0]};
            2'd2: begin
                neg = op[63];
                mag = neg ? (64'd0 - op) : op;
            end
            default: mag = op;
        endcase
        if (mag == 0) begin
            e.res = '0; e.cls = 5'b00010;
            return e;
        end
        top = 63;
        while (!mag[top]) top--;
        p = sg ? 24 : 53;
        up = 1'b0;
        if (top < p) begin
            q = mag << (p - 1 - top); r = 0;
        end else begin
            sh = top - (p - 1);
            q = mag >> sh;
            r = (sh == 0) ? 64'd0 : (mag & ((64'd1 << sh) - 1));
            half = (sh == 0) ? 64'd0 : (64'd1 << (sh - 1));
            case (rm)
                2'd0: up = (r > half) || (r == half && r != 0 && q[0]);
                2'd1: up = 1'b0;
                2'd2: up = (r != 0) && !neg;
                default: up = (r != 0) && neg;
            endcase
        end
        if (up) q = q + 1;
        if (q == (64'd1 << p)) begin q = q >> 1; top++; end
        e.res = {neg, 11'(top + 1023), 52'((q & ((64'd1 << (p - 1)) - 1)) << (53 - p))};
        e.ix  = (r != 0);
        e.up  = up;
        e.cls = neg ? 5'b01000 : 5'b00100;
        return e;
    endfunction

    task automatic chk(bit ok, string tag, string what, bit [63:0] got, bit [63:0] want);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
        end
    endtask

    // Compare the result due this cycle against the reference queue
    task automatic compare();
        exp_t x;
        if (pipe.size() == 2) begin
            x = pipe.pop_front();
            chk(out_valid == x.v, "R10", "out_valid", 64'(out_valid), 64'(x.v));
            if (x.v) begin
                chk(out_result == x.res, x.tag, "result", out_result, x.res);
                chk(out_inexact == x.ix, "R6", "inexact", 64'(out_inexact), 64'(x.ix));
                chk(out_rounded_up == x.up, "R7", "rounded_up", 64'(out_rounded_up), 64'(x.up));
                chk(out_class == x.cls, "R9", "class", 64'(out_class), 64'(x.cls));
                chk(out_status_we == x.we, x.tag, "status_we", 64'(out_status_we), 64'(x.we));
                if (x.we && x.ix) sticky_m = 1'b1;
                chk(out_sticky == sticky_m, "R8", "sticky", 64'(out_sticky), 64'(sticky_m));
            end
        end
    endtask

    task automatic step(bit v, bit [63:0] op, bit [1:0] ty, bit [1:0] rm, bit sg, string tag);
        exp_t e;
        @(negedge clk);
        compare();
        in_valid = v; in_operand = op; in_type = ty; in_rmode = rm; in_single = sg;
        if (v) e = model(op, ty, rm, sg, tag);
        else begin e = '{default: 0}; e.v = 1'b0; e.tag = "R10"; end
        pipe.push_back(e);
    endtask

    task automatic all_modes(bit [63:0] op, bit [1:0] ty, bit sg, string tag);
        for (int m = 0; m < 4; m++) step(1'b1, op, ty, 2'(m), sg, tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        bit [63:0] op;
        repeat (5) @(negedge clk);
        // R10: reset state
        chk(out_valid == 1'b0, "R10", "reset out_valid", 64'(out_valid), 64'd0);
        chk(out_sticky == 1'b0, "R10", "reset sticky", 64'(out_sticky), 64'd0);
        rst_n = 1'b1;

        // R3: exact binary64 conversions from 32-bit sources, any mode
        all_modes(64'h0000_0000_0000_0001, 2'd0, 1'b0, "R3");
        all_modes(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b0, "R3");
        all_modes(64'hDEAD_BEEF_8000_0000, 2'd0, 1'b0, "R3");
        all_modes(64'h1234_5678_FFFF_FFFF, 2'd1, 1'b0, "R3");
        // R1: high word ignored for 32-bit types
        step(1'b1, 64'hFFFF_0000_0000_0005, 2'd1, 2'd0, 1'b0, "R1");
        step(1'b1, 64'h1234_5678_7FFF_FFFF, 2'd0, 2'd0, 1'b0, "R1");
        step(1'b1, 64'h1234_5678_7FFF_FFFF, 2'd2, 2'd0, 1'b0, "R1");
        // R2: negatives and positive zero
        step(1'b1, 64'd0, 2'd0, 2'd3, 1'b0, "R2");
        step(1'b1, 64'd0, 2'd2, 2'd3, 1'b1, "R2");
        step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 2'd0, 1'b0, "R2");
        all_modes(64'h8000_0000_0000_0000, 2'd2, 1'b0, "R2");
        // R4: rounding above 2^53, both signs, ties to even, carry out
        all_modes(64'h0020_0000_0000_0001, 2'd3, 1'b0, "R4");
        all_modes(64'h0020_0000_0000_0003, 2'd3, 1'b0, "R4");
        all_modes(64'hFFDF_FFFF_FFFF_FFFF, 2'd2, 1'b0, "R4");
        all_modes(64'hFFDF_FFFF_FFFF_FFFD, 2'd2, 1'b0, "R4");
        all_modes(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, "R4");
        // R5: binary32 precision delivered in binary64 encoding
        all_modes(64'd16777217, 2'd1, 1'b1, "R5");
        all_modes(64'd16777219, 2'd1, 1'b1, "R5");
        all_modes(64'hFFFF_FFFF_FEFF_FFFD, 2'd0, 1'b1, "R5");
        all_modes(64'h0000_0000_7FFF_FFFF, 2'd0, 1'b1, "R5");
        all_modes(64'h7FFF_FFFF_FFFF_FFFF, 2'd2, 1'b1, "R5");
        step(1'b1, 64'd5, 2'd1, 2'd2, 1'b1, "R5");

        // R4/R5: pseudo-random mix with valid gaps
        for (int i = 0; i < 600; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            op = lfsr >> lfsr[5:0];
            step((i % 7) != 3, op, lfsr[7:6], lfsr[9:8], lfsr[10], "R4/R5");
        end
        step(1'b0, 64'd0, 2'd0, 2'd0, 1'b0, "R10");
        step(1'b0, 64'd0, 2'd0, 2'd0, 1'b0, "R10");
        step(1'b0, 64'd0, 2'd0, 2'd0, 1'b0, "R10");

        // R8: sticky cleared only by reset
        @(negedge clk);
        chk(out_sticky == 1'b1, "R8", "sticky before reset", 64'(out_sticky), 64'd1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_sticky == 1'b0, "R8", "sticky after reset", 64'(out_sticky), 64'd0);
        chk(out_valid == 1'b0, "R10", "valid after reset", 64'(out_valid), 64'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule